// File: doc/BRIEF.md
# Four-Channel Scaled Compare Timer

This block is a memory-mapped timer built around a free-running 31-bit counter. A 4-bit scale field selects a 16-bit window of that counter, starting at the chosen bit. The window is compared against four 16-bit compare registers. When the window value is at or above a channel's compare value, the channel's pending flag is raised one clock later and drives that channel's interrupt output. Software clears a pending flag by writing the configuration register with that flag at zero. If the match condition still holds, the flag comes back on the next clock.

The counter advances by one per clock while either of two enables is set. One enable stays on until software clears it. The other is a one-shot enable, and the hardware drops it by itself in two cases: when the counter rolls over from its top value, and when the zero-compare option is on and channel 0 matches. In the second case the counter is also cleared, which gives a period set by channel 0. Software can load the counter directly, or load it through the scaled view, where the written value is shifted up by the scale. The configuration bits for center alignment, ganging, deglitch and sticky output are stored and read back, but they have no effect.

Access goes through a single-cycle 32-bit register bus. Read data is registered.

Top module: `pwm4_timer`

## Requirements
- R1: During reset and right after it, the configuration, counter and compare registers read zero and all interrupt outputs are low.
- R2: While configuration bit 12 (always-enable) or bit 13 (one-shot enable) is set, the counter at offset 0x08 rises by one per clock and wraps from 0x7FFFFFFF to 0. With both bits clear it holds its value.
- R3: Writing offset 0x08 loads the counter with write bits 30:0. Reading offset 0x08 returns the counter, and bit 31 is always zero.
- R4: Reading offset 0x10 returns (counter >> scale) truncated to 16 bits, where scale is configuration bits 3:0. Writing offset 0x10 loads the counter with (write bits 15:0) << scale, truncated to 31 bits. This holds for scale 0 and scale 15.
- R5: The compare register of channel i is at offset 0x20 + 4*i. It keeps only the low 16 bits of a write, and its upper read bits are zero.
- R6: On the clock after the scaled value is greater than or equal to compare register i, pending bit 28+i of the configuration register is set and output irq[i] is high.
- R7: When configuration bit 9 (zero-compare) is set and channel 0 matches, the next clock clears the counter and clears bit 13.
- R8: When the counter wraps from 0x7FFFFFFF to 0 while counting, bit 13 is cleared on that same clock.
- R9: A configuration write sets each pending bit to the written bit 28+i, so writing it as zero lowers irq[i] for one clock. While the match persists, the bit and irq[i] return high on the following clock.
- R10: Reads from offsets other than 0x00, 0x08, 0x10 and 0x20..0x2C return zero. Writes to them change no register.
- R11: Configuration bits 27:0 that have no function (sticky 8, deglitch 10, center 19:16, gang 27:24 and the spare bits) read back as written.
- R12: Read data appears on rdata on the clock after the read request. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 4 | Per-channel interrupt, equal to the pending bits |

## Verification
The bench uses the default build: four channels, a 31-bit counter and 16-bit compare registers. It runs both ends of the scale field. Scale 15 lets a counter loaded near 0x7FFFFFF0 reach a scaled value of 0xFFFF and then roll over within a few clocks, so wrap, carry-out clearing of the one-shot enable and the top-of-range compare can all be checked without counting through two billion clocks. Scale 0 with small compare values covers zero-compare restarts and the drop-then-return of a pending bit within a few dozen cycles.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int CNT_W  = 31;
  localparam int CMP_W  = 16;
  localparam int SCL_W  = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CFG  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_RAW  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_SCL  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CMP0 = 8'h20;

  localparam int B_ZERO = 9;
  localparam int B_ALW  = 12;
  localparam int B_ONE  = 13;
  localparam int B_PEND = 28;

  // 16-bit window of the counter starting at bit "sc"
  function automatic logic [CMP_W-1:0] scaled_view(input logic [CNT_W-1:0] c,
                                                   input logic [SCL_W-1:0] sc);
    logic [CNT_W-1:0] sh;
    sh = c >> sc;
    return sh[CMP_W-1:0];
  endfunction

  // counter value that a scaled write loads
  function automatic logic [CNT_W-1:0] scaled_load(input logic [CMP_W-1:0] v,
                                                   input logic [SCL_W-1:0] sc);
    logic [CNT_W+CMP_W-1:0] w;
    w = {{CNT_W{1'b0}}, v} << sc;
    return w[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/pwm4_counter.sv
module pwm4_counter
  import pwm4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic              ld_raw,
  input  logic              ld_scl,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SCL_W-1:0]  scale,
  input  logic              zero_fire,
  output logic [CNT_W-1:0]  cnt,
  output logic              carry_out
);
  assign carry_out = count_en && (&cnt) && !ld_raw && !ld_scl && !zero_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (ld_raw)    cnt <= wdata[CNT_W-1:0];
    else if (ld_scl)    cnt <= scaled_load(wdata[CMP_W-1:0], scale);
    else if (zero_fire) cnt <= '0;
    else if (count_en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel
  import pwm4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_wr,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pend_wbit,
  input  logic [CMP_W-1:0]  scaled,
  output logic [CMP_W-1:0]  cmp,
  output logic              match,
  output logic              pend
);
  assign match = (scaled >= cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp  <= '0;
      pend <= 1'b0;
    end else begin
      if (cmp_wr) cmp <= wdata[CMP_W-1:0];
      if (cfg_wr) pend <= pend_wbit;
      else        pend <= pend | match;
    end
  end
endmodule

// File: rtl/pwm4_timer.sv
module pwm4_timer
  import pwm4_pkg::*;
#(
  parameter int NCHAN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCHAN-1:0]  irq
);
  localparam int CFG_LO = B_PEND;

  logic [CFG_LO-1:0]      cfg_q;
  logic [CNT_W-1:0]       cnt;
  logic [CMP_W-1:0]       scaled;
  logic [NCHAN-1:0]       match, pend;
  logic [CMP_W-1:0]       cmp_val [NCHAN];
  logic                   count_en, zero_fire, carry_out;
  logic                   cfg_wr, raw_wr, scl_wr;
  logic [DATA_W-1:0]      rd_val;
  logic [SCL_W-1:0]       scale;

  assign scale     = cfg_q[SCL_W-1:0];
  assign count_en  = cfg_q[B_ALW] | cfg_q[B_ONE];
  assign zero_fire = cfg_q[B_ZERO] & match[0];
  assign scaled    = scaled_view(cnt, scale);
  assign cfg_wr    = bus_wr && (bus_addr == OFF_CFG);
  assign raw_wr    = bus_wr && (bus_addr == OFF_RAW);
  assign scl_wr    = bus_wr && (bus_addr == OFF_SCL);
  assign irq       = pend;

  pwm4_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .ld_raw(raw_wr),
    .ld_scl(scl_wr), .wdata(bus_wdata), .scale(scale),
    .zero_fire(zero_fire), .cnt(cnt), .carry_out(carry_out)
  );

  for (genvar i = 0; i < NCHAN; i++) begin : g_ch
    logic cmp_wr;
    assign cmp_wr = bus_wr && (bus_addr == OFF_CMP0 + ADDR_W'(4*i));
    pwm4_channel u_ch (
      .clk(clk), .rst_n(rst_n), .cmp_wr(cmp_wr), .cfg_wr(cfg_wr),
      .wdata(bus_wdata), .pend_wbit(bus_wdata[B_PEND+i]), .scaled(scaled),
      .cmp(cmp_val[i]), .match(match[i]), .pend(pend[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cfg_q <= '0;
    else if (cfg_wr)                cfg_q <= bus_wdata[CFG_LO-1:0];
    else if (zero_fire | carry_out) cfg_q[B_ONE] <= 1'b0;
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == OFF_CFG) begin
      rd_val[CFG_LO-1:0]          = cfg_q;
      rd_val[B_PEND +: NCHAN]     = pend;
    end else if (bus_addr == OFF_RAW) begin
      rd_val[CNT_W-1:0] = cnt;
    end else if (bus_addr == OFF_SCL) begin
      rd_val[CMP_W-1:0] = scaled;
    end
    for (int i = 0; i < NCHAN; i++)
      if (bus_addr == OFF_CMP0 + ADDR_W'(4*i)) rd_val[CMP_W-1:0] = cmp_val[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/pwm4_timer_chk.sv
module pwm4_timer_chk
  import pwm4_pkg::*;
#(
  parameter int NCHAN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CNT_W-1:0]  cnt,
  input logic              count_en,
  input logic              zero_fire,
  input logic              cfg_one,
  input logic              cfg_wr,
  input logic [NCHAN-1:0]  match,
  input logic [NCHAN-1:0]  pend
);
  logic mapped;
  assign mapped = (bus_addr == OFF_CFG) || (bus_addr == OFF_RAW) ||
                  (bus_addr == OFF_SCL) ||
                  ((bus_addr >= OFF_CMP0) && (bus_addr <= OFF_CMP0 + ADDR_W'(4*(NCHAN-1)))
                   && (bus_addr[1:0] == 2'b00));

  // R2: counting advances by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !bus_wr && !zero_fire) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  // R2: disabled counter holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !bus_wr && !zero_fire) |=> $stable(cnt));
  // R6: a match always yields pending next clock unless config is written
  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ((pend & $past(match)) == $past(match)));
  // R6: pending never rises without a match
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ((pend & ~($past(pend) | $past(match))) == '0));
  // R7: zero-compare restart
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_fire && !bus_wr) |=> (cnt == '0 && !cfg_one));
  // R8: carry-out ends one-shot
  a_r8_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && (&cnt) && !bus_wr && !zero_fire) |=> (cnt == '0 && !cfg_one));
  // R3: bit 31 of the raw counter reads zero
  a_r3_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFF_RAW) |=> !bus_rdata[DATA_W-1]);
  // R10: unmapped reads give zero
  a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |=> (bus_rdata == '0));
  // R12: rdata holds without a read
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind pwm4_timer pwm4_timer_chk #(.NCHAN(NCHAN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .cnt(cnt),
  .count_en(count_en), .zero_fire(zero_fire), .cfg_one(cfg_q[pwm4_pkg::B_ONE]),
  .cfg_wr(cfg_wr), .match(match), .pend(pend)
);

// File: tb/sim_pwm4_timer.sv
`timescale 1ns/1ps
module sim_pwm4_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm4_timer u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
                 .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                 .bus_rdata(bus_rdata), .irq(irq));

  // behavioural reference
  longint      m_cnt;
  logic [31:0] m_cfg;
  int          m_cmp [4];
  logic [31:0] m_rdata;
  string       m_tag = "R1";

  function automatic longint m_scaled();
    return (m_cnt >> m_cfg[3:0]) & 64'hFFFF;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'h00) return m_cfg;
    if (a == 8'h08) return 32'(m_cnt);
    if (a == 8'h10) return 32'(m_scaled());
    if (a >= 8'h20 && a <= 8'h2C && a[1:0] == 2'b00) return 32'(m_cmp[(a - 8'h20) / 4]);
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h00) return "R11";
    if (a == 8'h08) return "R3";
    if (a == 8'h10) return "R4";
    if (a >= 8'h20 && a <= 8'h2C && a[1:0] == 2'b00) return "R5";
    return "R10";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cfg = '0; m_rdata = '0;
      for (int i = 0; i < 4; i++) m_cmp[i] = 0;
    end else begin
      bit mt [4];
      bit en, zc, cw, cy;
      longint nc;
      for (int i = 0; i < 4; i++) mt[i] = (m_scaled() >= m_cmp[i]);
      en = m_cfg[12] || m_cfg[13];
      zc = m_cfg[9] && mt[0];
      if (bus_rd) begin m_rdata = m_read(bus_addr); m_tag = tag_of(bus_addr); end
      cw = bus_wr && (bus_addr == 8'h08 || bus_addr == 8'h10);
      nc = m_cnt;
      if (bus_wr && bus_addr == 8'h08)      nc = bus_wdata & 32'h7FFFFFFF;
      else if (bus_wr && bus_addr == 8'h10) nc = (longint'(bus_wdata & 32'hFFFF) << m_cfg[3:0]) & 64'h7FFFFFFF;
      else if (zc)                          nc = 0;
      else if (en)                          nc = (m_cnt + 1) & 64'h7FFFFFFF;
      cy = en && (m_cnt == 64'h7FFFFFFF) && !cw && !zc;
      if (bus_wr && bus_addr == 8'h00) m_cfg = bus_wdata;
      else begin
        if (zc || cy) m_cfg[13] = 1'b0;
        for (int i = 0; i < 4; i++) if (mt[i]) m_cfg[28+i] = 1'b1;
      end
      for (int i = 0; i < 4; i++)
        if (bus_wr && bus_addr == 8'(8'h20 + 4*i)) m_cmp[i] = int'(bus_wdata & 32'hFFFF);
      m_cnt = nc;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // compare with the model on every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R6", {28'h0, irq}, {28'h0, m_cfg[31:28]});
      check(m_tag == "R1" ? "R12" : m_tag, bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] mask,
                        input logic [31:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata & mask, exp);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {28'h0, irq}, 32'h0);
    rst_n = 1'b1;
    // R1: registers zero after reset
    rd_exp(8'h08, 32'hFFFFFFFF, 32'h0, "R1");
    rd_exp(8'h24, 32'hFFFFFFFF, 32'h0, "R1");
    // R5: compare keeps low 16 bits
    wr(8'h20, 32'h0001FFFF); wr(8'h24, 32'hABCD0005);
    wr(8'h28, 32'h0000FFFF); wr(8'h2C, 32'h0000FFFF);
    rd_exp(8'h24, 32'hFFFFFFFF, 32'h00000005, "R5");
    rd_exp(8'h20, 32'hFFFFFFFF, 32'h0000FFFF, "R5");
    // R6: channel 1 pending one clock after scaled reaches 5
    wr(8'h08, 32'h0); wr(8'h00, 32'h00001000);
    repeat (5) @(negedge clk);
    check("R6", {31'h0, irq[1]}, 32'h0);
    @(negedge clk);
    check("R6", {31'h0, irq[1]}, 32'h1);
    // R2: counting from zero
    wr(8'h00, 32'h0); wr(8'h08, 32'h0); wr(8'h00, 32'h00001000);
    repeat (9) @(negedge clk);
    rd_exp(8'h08, 32'hFFFFFFFF, 32'd9, "R2");
    wr(8'h00, 32'h0);
    rd_exp(8'h08, 32'hFFFFFFFF, 32'd11, "R2");
    repeat (4) @(negedge clk);
    rd_exp(8'h08, 32'hFFFFFFFF, 32'd11, "R2");
    // R4: scale 15 and scale 0 through the scaled register
    wr(8'h00, 32'h0000000F); wr(8'h10, 32'h00000001);
    rd_exp(8'h08, 32'hFFFFFFFF, 32'h00008000, "R4");
    rd_exp(8'h10, 32'hFFFFFFFF, 32'h00000001, "R4");
    wr(8'h08, 32'h7FFFFFF0);
    rd_exp(8'h10, 32'hFFFFFFFF, 32'h0000FFFF, "R4");
    wr(8'h00, 32'h0); wr(8'h10, 32'h0001ABCD);
    rd_exp(8'h08, 32'hFFFFFFFF, 32'h0000ABCD, "R4");
    rd_exp(8'h10, 32'hFFFFFFFF, 32'h0000ABCD, "R4");
    // R3: raw write drops bit 31
    wr(8'h08, 32'hFFFFFFFF);
    rd_exp(8'h08, 32'hFFFFFFFF, 32'h7FFFFFFF, "R3");
    // R7: zero-compare with one-shot
    wr(8'h00, 32'h0); wr(8'h08, 32'h0); wr(8'h20, 32'd50);
    wr(8'h00, 32'h00002200);
    repeat (60) @(negedge clk);
    rd_exp(8'h00, 32'h00002200, 32'h00000200, "R7");
    rd_exp(8'h08, 32'hFFFFFFFF, 32'h0, "R7");
    // R8: wrap clears one-shot, scale 15 top of range
    wr(8'h00, 32'h0); wr(8'h08, 32'h7FFFFFF0); wr(8'h00, 32'h0000200F);
    repeat (30) @(negedge clk);
    rd_exp(8'h00, 32'h0000200F, 32'h0000000F, "R8");
    rd_exp(8'h08, 32'hFFFFFFFF, 32'h0, "R8");
    // R9: clear with persistent match on channel 2
    wr(8'h00, 32'h0); wr(8'h28, 32'h0);
    @(negedge clk);
    check("R9", {31'h0, irq[2]}, 32'h1);
    wr(8'h00, 32'h0);
    check("R9", {31'h0, irq[2]}, 32'h0);
    @(negedge clk);
    check("R9", {31'h0, irq[2]}, 32'h1);
    // R10: unmapped offsets
    rd_exp(8'h04, 32'hFFFFFFFF, 32'h0, "R10");
    rd_exp(8'h30, 32'hFFFFFFFF, 32'h0, "R10");
    wr(8'h18, 32'h12345678); wr(8'h22, 32'h00000077);
    rd_exp(8'h08, 32'hFFFFFFFF, 32'h0, "R10");
    rd_exp(8'h20, 32'hFFFFFFFF, 32'd50, "R10");
    rd_exp(8'h22, 32'hFFFFFFFF, 32'h0, "R10");
    // R11: inert config bits read back
    wr(8'h20, 32'hFFFF); wr(8'h24, 32'hFFFF); wr(8'h28, 32'hFFFF);
    wr(8'h00, 32'h0F0F0DF0);
    rd_exp(8'h00, 32'h0FFFFFFF, 32'h0F0F0DF0, "R11");
    // R12: rdata holds between reads
    repeat (3) @(negedge clk);
    check("R12", bus_rdata & 32'h0FFFFFFF, 32'h0F0F0DF0);
    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule